// File: doc/BRIEF.md
# Two-Slot Translation Shortcut Cache

This block sits beside a translation lookaside buffer and remembers the two translations used most recently, so a repeated access can be translated without a full search. Each slot holds the TLB entry index it came from, the virtual base, a page size code, the physical base and the address space identifier (ASI) the entry was used with. One control-state word covers both slots. It records the privilege and mode state that was active at the last fill. A global valid flag qualifies the whole cache.

A lookup is purely combinational. The requester presents an ASI, a virtual address, an access length and its current control word, and receives a hit flag, the slot that hit and the physical address in the same cycle. On a miss, the surrounding logic performs the full TLB search and pushes the winning entry in through the fill port. The fill takes effect at the next clock edge. Any change to the TLB is signalled on a single modification pulse, which disables every slot at once.

Top module: `ts_shortcut`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), `lk_hit` is 0 for every lookup until a fill has been accepted.
- R2: A hit requires the cache-valid flag to be set and the stored control word to equal `lk_ctrl`. A lookup whose `lk_ctrl` differs from the word recorded at the last accepted fill never hits.
- R3: A slot matches when all of the following hold: it is occupied, its stored ASI equals `lk_asi`, base < `lk_va` + `lk_len`, and base + 2^shift >= `lk_va`. The last comparison is inclusive, so an address one past the end of the page still matches.
- R4: Slot 0 is examined before slot 1. When both slots match, `lk_slot` is 0. `lk_slot` is 1 only when slot 1 alone matches.
- R5: An accepted fill whose `fl_id` is not held by any occupied slot moves the old slot 0 (entry and ASI together) into slot 1 and writes the new entry into slot 0.
- R6: When `fl_implicit` is 1, the ASI stored into slot 0 is 0 instead of `fl_asi`.
- R7: A `tlb_mod` pulse clears cache-valid, so the lookups that follow miss. A fill presented in the same cycle as `tlb_mod` is discarded.
- R8: An accepted fill whose `fl_id` is already held by an occupied slot leaves both slots unchanged. It still sets cache-valid and records `fl_ctrl`.
- R9: On a hit, `lk_pa` equals the slot's physical base with its low `shift` bits cleared, OR'd with the low `shift` bits of `lk_va`.
- R10: Lookup results depend combinationally on the current inputs and state. An accepted fill becomes visible to lookups in the cycle after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_asi | input | 4 | Lookup address space identifier |
| lk_va | input | 16 | Lookup virtual address |
| lk_len | input | 4 | Lookup access length in bytes |
| lk_ctrl | input | 4 | Current control-state word |
| lk_hit | output | 1 | Lookup hit |
| lk_slot | output | 1 | Slot that supplied the hit |
| lk_pa | output | 16 | Translated physical address |
| fl_en | input | 1 | Fill request |
| fl_id | input | 3 | TLB entry index of the filled entry |
| fl_base | input | 16 | Virtual base of the entry |
| fl_shift | input | 4 | log2 of the page size |
| fl_pbase | input | 16 | Physical base of the entry |
| fl_asi | input | 4 | ASI of the filling access |
| fl_implicit | input | 1 | Filling access was implicit |
| fl_ctrl | input | 4 | Control word at fill time |
| tlb_mod | input | 1 | TLB insert, demap or invalidate happened |

## Verification
Lookup outputs are due in the same cycle as their inputs. The bench therefore drives each lookup just after a falling edge and samples 2 ns later, well before the next rising edge. Fills and `tlb_mod` pulses are held across exactly one rising edge. The lookups that follow them are sampled from the next falling edge on, which is the first cycle in which R10 says the new state is visible. A sweep of addresses and lengths across every page edge compares each result against a model the bench keeps from the requirements. It also covers the same-cycle case of `tlb_mod` and a fill.

// File: rtl/ts_pkg.sv
package ts_pkg;
    parameter int VA_W    = 16;
    parameter int PA_W    = 16;
    parameter int ASI_W   = 4;
    parameter int CTRL_W  = 4;
    parameter int ID_W    = 3;
    parameter int SHIFT_W = 4;
    parameter int LEN_W   = 4;
    parameter int NSLOT   = 2;
    localparam int EXT_W  = VA_W + 2;

    typedef struct packed {
        logic               occ;
        logic [ID_W-1:0]    id;
        logic [VA_W-1:0]    base;
        logic [SHIFT_W-1:0] shift;
        logic [PA_W-1:0]    pbase;
        logic [ASI_W-1:0]   asi;
    } slot_t;

    function automatic logic span_ok(slot_t s, logic [VA_W-1:0] va,
                                     logic [LEN_W-1:0] len);
        logic [EXT_W-1:0] b, v, e, sz;
        b  = EXT_W'(s.base);
        v  = EXT_W'(va);
        e  = v + EXT_W'(len);
        sz = EXT_W'(1) << s.shift;
        return (b < e) && ((b + sz) >= v);
    endfunction

    function automatic logic [PA_W-1:0] form_pa(slot_t s, logic [VA_W-1:0] va);
        logic [PA_W-1:0] m;
        m = (PA_W'(1) << s.shift) - PA_W'(1);
        return (s.pbase & ~m) | (PA_W'(va) & m);
    endfunction
endpackage

// File: rtl/ts_slot_match.sv
module ts_slot_match
    import ts_pkg::*;
(
    input  slot_t             slot,
    input  logic [ASI_W-1:0]  asi,
    input  logic [VA_W-1:0]   va,
    input  logic [LEN_W-1:0]  len,
    output logic              match,
    output logic [PA_W-1:0]   pa
);
    always_comb begin
        match = slot.occ && (slot.asi == asi) && span_ok(slot, va, len);
        pa    = form_pa(slot, va);
    end
endmodule

// File: rtl/ts_slot_store.sv
module ts_slot_store
    import ts_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fl_en,
    input  logic [ID_W-1:0]     fl_id,
    input  logic [VA_W-1:0]     fl_base,
    input  logic [SHIFT_W-1:0]  fl_shift,
    input  logic [PA_W-1:0]     fl_pbase,
    input  logic [ASI_W-1:0]    fl_asi,
    input  logic                fl_implicit,
    input  logic [CTRL_W-1:0]   fl_ctrl,
    input  logic                tlb_mod,
    output slot_t [NSLOT-1:0]   slots,
    output logic                cvalid,
    output logic [CTRL_W-1:0]   ctrl_q
);
    slot_t [NSLOT-1:0] slot_q;
    slot_t             incoming;
    logic              held;
    logic              take;

    always_comb begin
        held = 1'b0;
        for (int i = 0; i < NSLOT; i++)
            if (slot_q[i].occ && slot_q[i].id == fl_id) held = 1'b1;
        incoming.occ   = 1'b1;
        incoming.id    = fl_id;
        incoming.base  = fl_base;
        incoming.shift = fl_shift;
        incoming.pbase = fl_pbase;
        incoming.asi   = fl_implicit ? '0 : fl_asi;
        take = fl_en && !tlb_mod;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cvalid <= 1'b0;
            ctrl_q <= '0;
            slot_q <= '0;
        end else if (tlb_mod) begin
            cvalid <= 1'b0;
        end else if (fl_en) begin
            cvalid <= 1'b1;
            ctrl_q <= fl_ctrl;
            if (!held) begin
                for (int i = NSLOT-1; i > 0; i--) slot_q[i] <= slot_q[i-1];
                slot_q[0] <= incoming;
            end
        end
    end

    assign slots = slot_q;

    a_r5_shift_down: assert property (@(posedge clk) disable iff (rst)
        take && !held |=> slot_q[1] == $past(slot_q[0]) && slot_q[0].id == $past(fl_id));
    a_r6_implicit_zero: assert property (@(posedge clk) disable iff (rst)
        take && !held && fl_implicit |=> slot_q[0].asi == '0);
    a_r7_mod_clears: assert property (@(posedge clk) disable iff (rst)
        tlb_mod |=> !cvalid && $stable(slot_q));
    a_r8_held_stable: assert property (@(posedge clk) disable iff (rst)
        take && held |=> $stable(slot_q) && cvalid);
endmodule

// File: rtl/ts_shortcut.sv
module ts_shortcut
    import ts_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ASI_W-1:0]    lk_asi,
    input  logic [VA_W-1:0]     lk_va,
    input  logic [LEN_W-1:0]    lk_len,
    input  logic [CTRL_W-1:0]   lk_ctrl,
    output logic                lk_hit,
    output logic                lk_slot,
    output logic [PA_W-1:0]     lk_pa,
    input  logic                fl_en,
    input  logic [ID_W-1:0]     fl_id,
    input  logic [VA_W-1:0]     fl_base,
    input  logic [SHIFT_W-1:0]  fl_shift,
    input  logic [PA_W-1:0]     fl_pbase,
    input  logic [ASI_W-1:0]    fl_asi,
    input  logic                fl_implicit,
    input  logic [CTRL_W-1:0]   fl_ctrl,
    input  logic                tlb_mod
);
    slot_t [NSLOT-1:0]  slots;
    logic               cvalid;
    logic [CTRL_W-1:0]  ctrl_q;
    logic [NSLOT-1:0]   match;
    logic [PA_W-1:0]    pa_s [NSLOT];
    logic [NSLOT-1:0]   pick;
    logic               state_ok;

    ts_slot_store u_store (
        .clk(clk), .rst(rst), .fl_en(fl_en), .fl_id(fl_id), .fl_base(fl_base),
        .fl_shift(fl_shift), .fl_pbase(fl_pbase), .fl_asi(fl_asi),
        .fl_implicit(fl_implicit), .fl_ctrl(fl_ctrl), .tlb_mod(tlb_mod),
        .slots(slots), .cvalid(cvalid), .ctrl_q(ctrl_q)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_match
        ts_slot_match u_match (
            .slot(slots[g]), .asi(lk_asi), .va(lk_va), .len(lk_len),
            .match(match[g]), .pa(pa_s[g])
        );
    end

    always_comb begin
        state_ok = cvalid && (ctrl_q == lk_ctrl);
        pick     = '0;
        lk_hit   = 1'b0;
        lk_slot  = 1'b0;
        lk_pa    = '0;
        for (int i = NSLOT-1; i >= 0; i--) begin
            if (state_ok && match[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
                lk_hit  = 1'b1;
                lk_slot = 1'(i);
                lk_pa   = pa_s[i];
            end
        end
    end

    a_r4_single_pick: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pick) && (lk_hit == (pick != '0)));
    a_r4_slot0_first: assert property (@(posedge clk) disable iff (rst)
        state_ok && match[0] |-> lk_hit && !lk_slot);
    a_r7_miss_after_mod: assert property (@(posedge clk) disable iff (rst)
        tlb_mod |=> !lk_hit);
    a_r2_ctrl_gate: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> ctrl_q == lk_ctrl);
endmodule

// File: tb/ts_shortcut_bench.sv
module ts_shortcut_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic [3:0]  lk_asi = 0, lk_len = 1, lk_ctrl = 0;
    logic [15:0] lk_va = 0;
    logic        lk_hit, lk_slot;
    logic [15:0] lk_pa;
    logic        fl_en = 0, fl_implicit = 0, tlb_mod = 0;
    logic [2:0]  fl_id = 0;
    logic [15:0] fl_base = 0, fl_pbase = 0;
    logic [3:0]  fl_shift = 0, fl_asi = 0, fl_ctrl = 0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    int m_occ[2], m_id[2], m_base[2], m_shift[2], m_pbase[2], m_asi[2];
    int m_cv = 0, m_ctrl = 0;

    always #4 clk = ~clk;

    ts_shortcut u_ts_shortcut (
        .clk(clk), .rst(rst), .lk_asi(lk_asi), .lk_va(lk_va), .lk_len(lk_len),
        .lk_ctrl(lk_ctrl), .lk_hit(lk_hit), .lk_slot(lk_slot), .lk_pa(lk_pa),
        .fl_en(fl_en), .fl_id(fl_id), .fl_base(fl_base), .fl_shift(fl_shift),
        .fl_pbase(fl_pbase), .fl_asi(fl_asi), .fl_implicit(fl_implicit),
        .fl_ctrl(fl_ctrl), .tlb_mod(tlb_mod)
    );

    task automatic lookup(input int asi, input int va, input int len,
                          input int ctrl, input string tag);
        int eh, es, ep, sz;
        @(negedge clk);
        lk_asi = 4'(asi); lk_va = 16'(va); lk_len = 4'(len); lk_ctrl = 4'(ctrl);
        #2;
        eh = 0; es = 0; ep = 0;
        if (m_cv != 0 && m_ctrl == ctrl) begin
            for (int s = 1; s >= 0; s--) begin
                sz = 1 << m_shift[s];
                if (m_occ[s] != 0 && m_asi[s] == asi && m_base[s] < va + len
                    && m_base[s] + sz >= va) begin
                    eh = 1; es = s;
                    ep = ((m_pbase[s] & ~(sz - 1)) | (va & (sz - 1))) & 16'hFFFF;
                end
            end
        end
        n_chk++;
        if (lk_hit !== 1'(eh) || (eh != 0 && (lk_slot !== 1'(es) || lk_pa !== 16'(ep)))) begin
            n_bad++;
            $display("FAIL %s va=%h len=%0d asi=%0d: got hit=%b slot=%b pa=%h, expected hit=%0d slot=%0d pa=%h",
                     tag, va, len, asi, lk_hit, lk_slot, lk_pa, eh, es, ep);
        end
    endtask

    task automatic sweep(input int asi, input int ctrl, input string tag);
        for (int va = 'hF0; va < 'h240; va++)
            for (int len = 1; len <= 4; len = len * 2)
                lookup(asi, va, len, ctrl, tag);
    endtask

    task automatic fill(input int id, input int base, input int shift,
                        input int pbase, input int asi, input int impl,
                        input int ctrl, input int mod);
        int held;
        @(negedge clk);
        fl_en = 1; fl_id = 3'(id); fl_base = 16'(base); fl_shift = 4'(shift);
        fl_pbase = 16'(pbase); fl_asi = 4'(asi); fl_implicit = 1'(impl);
        fl_ctrl = 4'(ctrl); tlb_mod = 1'(mod);
        @(negedge clk);
        fl_en = 0; tlb_mod = 0;
        if (mod != 0) m_cv = 0;
        else begin
            held = 0;
            for (int s = 0; s < 2; s++) if (m_occ[s] != 0 && m_id[s] == id) held = 1;
            m_cv = 1; m_ctrl = ctrl;
            if (held == 0) begin
                m_occ[1] = m_occ[0]; m_id[1] = m_id[0]; m_base[1] = m_base[0];
                m_shift[1] = m_shift[0]; m_pbase[1] = m_pbase[0]; m_asi[1] = m_asi[0];
                m_occ[0] = 1; m_id[0] = id; m_base[0] = base; m_shift[0] = shift;
                m_pbase[0] = pbase; m_asi[0] = (impl != 0) ? 0 : asi;
            end
        end
    endtask

    task automatic pulse_mod();
        @(negedge clk);
        tlb_mod = 1;
        @(negedge clk);
        tlb_mod = 0;
        m_cv = 0;
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_occ[s] = 0; m_id[s] = 0; m_base[s] = 0;
            m_shift[s] = 0; m_pbase[s] = 0; m_asi[s] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R1: reset state, nothing hits
        lookup(0, 0, 1, 0, "R1 reset");
        sweep(0, 0, "R1 reset sweep");
        // R3 R9 R10: single entry, page edges and translation
        fill(1, 'h100, 4, 'h5A37, 3, 0, 5, 0);
        sweep(3, 5, "R3 R9 R10 single");
        // R2: control mismatch, R3: ASI mismatch
        sweep(3, 6, "R2 ctrl");
        sweep(2, 5, "R3 asi");
        // R5 R4: second entry overlaps, slot0 wins
        fill(2, 'h108, 3, 'h7700, 3, 0, 5, 0);
        sweep(3, 5, "R4 R5 shift");
        // R8: refill held id with a new ASI and control word
        fill(1, 'h100, 4, 'h1111, 9, 0, 6, 0);
        sweep(3, 6, "R8 held");
        sweep(9, 6, "R8 asi");
        // R7: modification pulse, then fill together with pulse
        pulse_mod();
        sweep(3, 6, "R7 mod");
        fill(4, 'h200, 5, 'hC000, 3, 0, 6, 1);
        sweep(3, 6, "R7 same cycle");
        // R6: implicit fill stores ASI 0
        fill(3, 'h200, 5, 'hBE00, 7, 1, 9, 0);
        sweep(0, 9, "R6 implicit");
        sweep(7, 9, "R6 asi7");
        sweep(3, 9, "R5 evicted");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule